// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects forty external interrupt lines, arranged as a 32-line first bank and an 8-line second bank, and turns selected activity on them into interrupt requests for a downstream interrupt controller. Each line carries six control bits: an interrupt enable, an event enable, a rising-edge select, a falling-edge select, a software trigger and a pending flag. Hardware inputs are synchronised, and their edges are detected. A selected edge on an enabled line latches the pending flag. A fresh pending flag produces a single-cycle request pulse on that line's output.

Software reaches the block through a simple 32-bit register bus with write strobe and combinational read data. A 0-to-1 write to a software trigger bit of an enabled line raises the pending flag just as a hardware edge would. Writing ones to the pending register clears those flags and their software trigger bits. Some lines are direct lines. Their select, software and pending bits are tied to zero, so these lines never latch anything here.

Top module: `xint_line_ctrl`

## Requirements
- R1: After reset every register reads zero and no request pulse is produced.
- R2: Byte offsets within a bank: interrupt enable 0x00, event enable 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. The second bank is the same set plus 0x20. Any other offset (0x18, 0x1C, 0x38, 0x3C, or an address with bits 1:0 non-zero) reads zero and writes nothing.
- R3: Both enable registers of the first bank store all 32 bits. In the second bank the enable registers store bits 7:0 only.
- R4: Rising and falling select registers keep only the bits in 0x007DFFFF (first bank) and 0x00000078 (second bank).
- R5: Direct-line bits (0xFF820000 in the first bank, 0x00000087 in the second) and bits 31:8 of every second-bank register ignore writes to the select, software trigger and pending registers and read zero.
- R6: Writing a software trigger bit from 0 to 1 while its line is enabled sets the pending bit, produces one request pulse, and the software bit reads 1.
- R7: A software trigger bit written to 1 while its line is disabled is stored but sets no pending bit. Enabling the line later, or writing 1 again over a stored 1, sets nothing.
- R8: Writing 1 to a pending bit clears it and the matching software trigger bit. Writing 0 leaves it unchanged.
- R9: A hardware rising edge sets pending only when the rising select bit is set. A falling edge sets pending only when the falling select bit is set. With neither set, no pending bit is set. Line k of `line_in` maps to first-bank bit k for k below 32 and to second-bank bit k-32 otherwise. A pending bit is readable by the third clock edge after the input change.
- R10: A hardware edge seen while the line is disabled is not remembered. Enabling the line afterwards sets no pending bit.
- R11: Request output bit k pulses high for exactly one cycle, in the cycle its pending bit turns from 0 to 1. No further pulse occurs while the bit stays pending, and clearing pending does not alter a pulse already issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| line_in | input | 40 | Asynchronous hardware interrupt lines |
| irq_pulse | output | 40 | Per-line single-cycle interrupt request |

## Verification
On every cycle, the assertions inside each bank check four things. A pending bit can only appear on a line that was enabled in the cycle before. A write of 1 to a pending bit clears both the pending bit and its software trigger bit unless a new event arrives at the same edge. Each request pulse matches a fresh 0-to-1 pending transition and never lasts two cycles. The directed scenarios are needed for the register masks, the direct-line bits, the edge-select combinations, the refusal to latch events retroactively on enabling, and the bank-to-line mapping, since these depend on values software writes and reads back.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned REG_NUM   = 6;
  localparam int unsigned IDX_W     = 3;

  typedef enum logic [IDX_W-1:0] {
    RI_IMASK  = 3'd0,
    RI_EMASK  = 3'd1,
    RI_RISE   = 3'd2,
    RI_FALL   = 3'd3,
    RI_SWTRIG = 3'd4,
    RI_PEND   = 3'd5
  } reg_idx_e;

  function automatic int unsigned bank_width(int unsigned b);
    return (b == 0) ? 32 : 8;
  endfunction

  function automatic int unsigned bank_base(int unsigned b);
    return (b == 0) ? 0 : 32;
  endfunction

  localparam int unsigned TOTAL_LINES = bank_base(NUM_BANKS - 1) + bank_width(NUM_BANKS - 1);

  function automatic logic [DATA_W-1:0] enable_keep(int unsigned b);
    return (b == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
  endfunction

  function automatic logic [DATA_W-1:0] trig_keep(int unsigned b);
    return (b == 0) ? 32'h007D_FFFF : 32'h0000_0078;
  endfunction

  function automatic logic [REG_NUM-1:0] idx_onehot(logic [IDX_W-1:0] idx, logic hit);
    logic [REG_NUM-1:0] oh;
    oh = '0;
    for (int i = 0; i < REG_NUM; i++)
      if (hit && (idx == IDX_W'(i))) oh[i] = 1'b1;
    return oh;
  endfunction
endpackage

// File: rtl/xint_sync_edge.sv
module xint_sync_edge #(
  parameter int unsigned W      = 40,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= '0;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      last_q <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/xint_bank.sv
module xint_bank
  import xint_pkg::*;
#(
  parameter int unsigned     W         = 32,
  parameter logic [W-1:0]    EN_KEEP   = '1,
  parameter logic [W-1:0]    TRIG_KEEP = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_NUM-1:0] wr_sel,
  input  logic [W-1:0]       wdata,
  input  logic [W-1:0]       rise_i,
  input  logic [W-1:0]       fall_i,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic [W-1:0]       irq_o
);
  logic [W-1:0] imask_q, emask_q, rsel_q, fsel_q, sw_q, pend_q, irq_q;
  logic [W-1:0] wdata_trig, sw_set, hw_hit, pr_clr, set_evt, pend_d;

  assign wdata_trig = wdata & TRIG_KEEP;
  // software trigger fires on a 0->1 write of an enabled line only
  assign sw_set  = wr_sel[RI_SWTRIG] ? (wdata_trig & ~sw_q & imask_q) : '0;
  assign hw_hit  = ((rise_i & rsel_q) | (fall_i & fsel_q)) & imask_q;
  assign pr_clr  = wr_sel[RI_PEND] ? wdata_trig : '0;
  assign set_evt = sw_set | hw_hit;
  // a new event at the same edge as a clear wins
  assign pend_d  = (pend_q & ~pr_clr) | set_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rsel_q  <= '0;
      fsel_q  <= '0;
      sw_q    <= '0;
      pend_q  <= '0;
      irq_q   <= '0;
    end else begin
      if (wr_sel[RI_IMASK]) imask_q <= wdata & EN_KEEP;
      if (wr_sel[RI_EMASK]) emask_q <= wdata & EN_KEEP;
      if (wr_sel[RI_RISE])  rsel_q  <= wdata_trig;
      if (wr_sel[RI_FALL])  fsel_q  <= wdata_trig;
      if (wr_sel[RI_SWTRIG]) sw_q <= wdata_trig;
      else                   sw_q <= sw_q & ~pr_clr;
      pend_q <= pend_d;
      irq_q  <= pend_d & ~pend_q;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    case (rd_idx)
      RI_IMASK:  rd_data = DATA_W'(imask_q);
      RI_EMASK:  rd_data = DATA_W'(emask_q);
      RI_RISE:   rd_data = DATA_W'(rsel_q);
      RI_FALL:   rd_data = DATA_W'(fsel_q);
      RI_SWTRIG: rd_data = DATA_W'(sw_q);
      RI_PEND:   rd_data = DATA_W'(pend_q);
      default:   rd_data = '0;
    endcase
  end

  // new pending bits only on lines enabled in the previous cycle
  assert_pend_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(imask_q)) == '0);

  // a clear with no competing event empties the pending bit
  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pr_clr & ~set_evt) & pend_q) == '0);

  // clearing pending also drops the software trigger bit
  assert_sw_follows_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pr_clr) & sw_q) == '0);

  // every pulse marks a fresh pending bit
  assert_irq_marks_new_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~(pend_q & ~$past(pend_q))) == '0);

  // pulses last one cycle
  assert_irq_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & $past(irq_o)) == '0);
endmodule

// File: rtl/xint_line_ctrl.sv
module xint_line_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [TOTAL_LINES-1:0] line_in,
  output logic [TOTAL_LINES-1:0] irq_pulse
);
  localparam int unsigned BANK_BIT = ADDR_W - 1;

  logic                   aligned, bank_sel;
  logic [IDX_W-1:0]       reg_idx;
  logic [TOTAL_LINES-1:0] rise_all, fall_all;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign bank_sel = bus_addr[BANK_BIT];
  assign reg_idx  = bus_addr[IDX_W+1:2];

  xint_sync_edge #(.W(TOTAL_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (line_in),
    .rise_o (rise_all),
    .fall_o (fall_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned    BW = bank_width(b);
    localparam int unsigned    LO = bank_base(b);
    localparam logic [DATA_W-1:0] EK = enable_keep(b);
    localparam logic [DATA_W-1:0] TK = trig_keep(b);

    logic [REG_NUM-1:0] wsel;
    logic               wr_hit;

    assign wr_hit = bus_sel && bus_wr && aligned && (bank_sel == b[0]);
    assign wsel   = idx_onehot(reg_idx, wr_hit);

    xint_bank #(.W(BW), .EN_KEEP(EK[BW-1:0]), .TRIG_KEEP(TK[BW-1:0])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wsel),
      .wdata   (bus_wdata[BW-1:0]),
      .rise_i  (rise_all[LO +: BW]),
      .fall_i  (fall_all[LO +: BW]),
      .rd_idx  (reg_idx),
      .rd_data (bank_rd[b]),
      .irq_o   (irq_pulse[LO +: BW])
    );
  end

  assign bus_rdata = aligned ? bank_rd[bank_sel] : '0;
endmodule

// File: tb/test_xint_line_ctrl.sv
module test_xint_line_ctrl;
  localparam int N = 40;
  localparam logic [5:0] A_EN0 = 6'h00, A_EV0 = 6'h04, A_RS0 = 6'h08, A_FS0 = 6'h0C,
                         A_SW0 = 6'h10, A_PD0 = 6'h14, A_EN1 = 6'h20, A_EV1 = 6'h24,
                         A_RS1 = 6'h28, A_FS1 = 6'h2C, A_SW1 = 6'h30, A_PD1 = 6'h34;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] line_in = '0, irq_pulse;
  int checks = 0, failures = 0;
  int irq_cnt [N];

  always #2 clk = ~clk;

  xint_line_ctrl i_xint_line_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .irq_pulse(irq_pulse)
  );

  initial for (int i = 0; i < N; i++) irq_cnt[i] = 0;
  always @(negedge clk) if (rst_n) for (int i = 0; i < N; i++) if (irq_pulse[i]) irq_cnt[i]++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [5:0] addrs [12] = '{A_EN0, A_EV0, A_RS0, A_FS0, A_SW0, A_PD0,
                               A_EN1, A_EV1, A_RS1, A_FS1, A_SW1, A_PD1};
    for (int i = 0; i < 12; i++) rd_check("R1 reset value", addrs[i], 32'h0);
    check("R1 no pulse after reset", 32'(irq_cnt[0] + irq_cnt[35]), 32'h0);
  endtask

  task automatic t_enables();
    wr(A_EN0, 32'hFFFF_FFFF); rd_check("R3 bank0 enable", A_EN0, 32'hFFFF_FFFF);
    wr(A_EV0, 32'hFFFF_FFFF); rd_check("R3 bank0 event enable", A_EV0, 32'hFFFF_FFFF);
    wr(A_EN1, 32'hFFFF_FFFF); rd_check("R3 bank1 enable", A_EN1, 32'h0000_00FF);
    wr(A_EV1, 32'hFFFF_FFFF); rd_check("R3 bank1 event enable", A_EV1, 32'h0000_00FF);
    rd_check("R2 bank1 write left bank0", A_EN0, 32'hFFFF_FFFF);
    wr(A_EN0, 32'h0); wr(A_EV0, 32'h0); wr(A_EN1, 32'h0); wr(A_EV1, 32'h0);
    rd_check("R3 bank0 enable cleared", A_EN0, 32'h0);
    wr(6'h18, 32'hFFFF_FFFF);
    rd_check("R2 unmapped offset reads zero", 6'h18, 32'h0);
    rd_check("R2 unmapped write harmless", A_EN0, 32'h0);
    wr(6'h01, 32'hFFFF_FFFF);
    rd_check("R2 misaligned write ignored", A_EN0, 32'h0);
  endtask

  task automatic t_selects();
    wr(A_RS0, 32'hFFFF_FFFF); rd_check("R4 bank0 rising select", A_RS0, 32'h007D_FFFF);
    wr(A_FS0, 32'hFFFF_FFFF); rd_check("R4 bank0 falling select", A_FS0, 32'h007D_FFFF);
    wr(A_RS1, 32'hFFFF_FFFF); rd_check("R4 bank1 rising select", A_RS1, 32'h0000_0078);
    wr(A_FS1, 32'hFFFF_FFFF); rd_check("R4 bank1 falling select", A_FS1, 32'h0000_0078);
    wr(A_RS0, 32'h0); wr(A_FS0, 32'h0); wr(A_RS1, 32'h0); wr(A_FS1, 32'h0);
    rd_check("R4 select cleared", A_RS1, 32'h0);
  endtask

  task automatic t_direct();
    logic [5:0] b0 [4] = '{A_RS0, A_FS0, A_SW0, A_PD0};
    logic [5:0] b1 [4] = '{A_RS1, A_FS1, A_SW1, A_PD1};
    for (int i = 0; i < 4; i++) begin
      wr(b0[i], 32'hFF82_0000); rd_check("R5 bank0 direct bits", b0[i], 32'h0);
      wr(b1[i], 32'h0000_0087); rd_check("R5 bank1 direct bits", b1[i], 32'h0);
      wr(b1[i], 32'hFFFF_FF00); rd_check("R5 bank1 reserved bits", b1[i], 32'h0);
    end
    wr(A_EN1, 32'hFFFF_FF00); rd_check("R5 bank1 enable reserved", A_EN1, 32'h0);
  endtask

  task automatic t_sw_trigger();
    int c0, c35;
    c0 = irq_cnt[0]; c35 = irq_cnt[35];
    wr(A_EN0, 32'h1); wr(A_SW0, 32'h0); wr(A_SW0, 32'h1);
    rd_check("R6 software bit reads one", A_SW0, 32'h1);
    rd_check("R6 pending set by software", A_PD0, 32'h1);
    check("R6 one request pulse line0", 32'(irq_cnt[0] - c0), 32'h1);
    wr(A_PD0, 32'h0);
    rd_check("R8 write zero keeps pending", A_PD0, 32'h1);
    wr(A_PD0, 32'h1);
    rd_check("R8 pending cleared", A_PD0, 32'h0);
    rd_check("R8 software bit cleared", A_SW0, 32'h0);
    check("R11 no extra pulse on clear", 32'(irq_cnt[0] - c0), 32'h1);
    wr(A_EN1, 32'h8); wr(A_SW1, 32'h0); wr(A_SW1, 32'h8);
    rd_check("R6 bank1 software bit", A_SW1, 32'h8);
    rd_check("R6 bank1 pending", A_PD1, 32'h8);
    check("R6 pulse on line 35", 32'(irq_cnt[35] - c35), 32'h1);
    wr(A_PD1, 32'h8);
    rd_check("R8 bank1 pending cleared", A_PD1, 32'h0);
    rd_check("R8 bank1 software cleared", A_SW1, 32'h0);
    wr(A_EN0, 32'h0); wr(A_EN1, 32'h0);
  endtask

  task automatic t_sw_masked();
    int c0;
    c0 = irq_cnt[0];
    wr(A_EN0, 32'h0); wr(A_SW0, 32'h0); wr(A_SW0, 32'h1);
    rd_check("R7 software bit stored", A_SW0, 32'h1);
    rd_check("R7 no pending while disabled", A_PD0, 32'h0);
    wr(A_EN0, 32'h1);
    rd_check("R7 no pending after enabling", A_PD0, 32'h0);
    wr(A_SW0, 32'h1);
    rd_check("R7 rewrite of one sets nothing", A_PD0, 32'h0);
    check("R7 no pulse", 32'(irq_cnt[0] - c0), 32'h0);
    wr(A_SW0, 32'h0); wr(A_EN0, 32'h0);
  endtask

  task automatic t_hw_edges();
    int c0, c35;
    c0 = irq_cnt[0]; c35 = irq_cnt[35];
    wr(A_EN0, 32'h1); wr(A_RS0, 32'h1); wr(A_FS0, 32'h0);
    line_in[0] = 1'b1; settle();
    rd_check("R9 rising edge sets pending", A_PD0, 32'h1);
    check("R11 pulse on rising edge", 32'(irq_cnt[0] - c0), 32'h1);
    line_in[0] = 1'b1; settle(); line_in[0] = 1'b1;
    line_in[0] = 1'b0; settle(); line_in[0] = 1'b1; settle();
    rd_check("R11 still pending", A_PD0, 32'h1);
    check("R11 no second pulse while pending", 32'(irq_cnt[0] - c0), 32'h1);
    wr(A_PD0, 32'h1);
    line_in[0] = 1'b0; settle();
    rd_check("R9 falling ignored with rising select", A_PD0, 32'h0);
    wr(A_RS0, 32'h0); wr(A_FS0, 32'h1);
    line_in[0] = 1'b1; settle();
    rd_check("R9 rising ignored with falling select", A_PD0, 32'h0);
    line_in[0] = 1'b0; settle();
    rd_check("R9 falling edge sets pending", A_PD0, 32'h1);
    wr(A_PD0, 32'h1); wr(A_FS0, 32'h0);
    line_in[0] = 1'b1; settle(); line_in[0] = 1'b0; settle();
    rd_check("R9 no select no pending", A_PD0, 32'h0);
    check("R9 pulse total line0", 32'(irq_cnt[0] - c0), 32'h2);
    wr(A_EN0, 32'h0);
    wr(A_EN1, 32'h8); wr(A_RS1, 32'h8);
    line_in[35] = 1'b1; settle();
    rd_check("R9 line35 maps to bank1 bit3", A_PD1, 32'h8);
    check("R9 pulse on line 35", 32'(irq_cnt[35] - c35), 32'h1);
    wr(A_PD1, 32'h8); wr(A_EN1, 32'h0); wr(A_RS1, 32'h0);
    line_in[35] = 1'b0; settle();
  endtask

  task automatic t_hw_masked();
    int c1;
    c1 = irq_cnt[1];
    wr(A_EN0, 32'h0); wr(A_RS0, 32'h2);
    line_in[1] = 1'b1; settle();
    rd_check("R10 disabled edge no pending", A_PD0, 32'h0);
    wr(A_EN0, 32'h2); settle();
    rd_check("R10 no retroactive pending", A_PD0, 32'h0);
    check("R10 no pulse", 32'(irq_cnt[1] - c1), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_selects();
    t_direct();
    t_sw_trigger();
    t_sw_masked();
    t_hw_edges();
    t_hw_masked();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule